// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead-Time

This block sits between a PWM source and the two gate drivers of a half bridge. It takes one active-high command for the low-side switch and one for the high-side switch, and produces two gate-enable outputs. It never drives both outputs high together. When both commands are high it treats this as an interlock condition and turns both outputs off. After either output turns off, the opposite output is held off for a programmable number of clock cycles. This dead-time is counted from the moment the output actually switched off, not from a command edge.

Two undervoltage-lockout flags come from analog comparators that already have hysteresis. The main-supply flag forces both outputs off. The floating-supply flag forces only the high-side output off. All four inputs pass through a synchronizer, so a change at an input reaches the outputs a fixed number of cycles later. A forced turn-off also starts a dead-time on the opposite output, in the same way as a commanded turn-off. The default dead-time is 32 cycles, which is 320 ns at 100 MHz.

Top module: `hb_gate_ctl`

## Requirements
- R1: Input-to-output mapping, with the outputs settled: both commands low gives both outputs low; only `cmd_hi` high gives only `gate_hi` high; only `cmd_lo` high gives only `gate_lo` high; both commands high gives both outputs low.
- R2: `gate_lo` and `gate_hi` are never high in the same cycle.
- R3: After `gate_lo` falls, `gate_hi` stays low for exactly `DEAD_CYC` cycles. It rises on the `DEAD_CYC`-th clock edge after the fall if its command is already waiting.
- R4: After `gate_hi` falls, `gate_lo` stays low for exactly `DEAD_CYC` cycles, with the same timing as R3.
- R5: After an overlap of both commands, the remaining output turns on `DEAD_CYC` cycles after the output that was on went off, no matter when the overlap ends.
- R6: When the gap between one command dropping and the other rising is at least `DEAD_CYC` cycles, the output follows the input with a fixed latency of `SYNC_STAGES+1` cycles (3 by default). With a gap one cycle shorter, the output rises one cycle later than that.
- R7: While `uvlo_main` is high, both outputs are low. The flag takes effect with the same latency as a command.
- R8: While `uvlo_float` is high, `gate_hi` is low and `gate_lo` still follows its command.
- R9: While `rst_n` is low, both outputs are low. After reset is released, the first command turns its output on after the fixed latency, with no dead-time wait.
- R10: If a command drops while a dead-time is running, its output stays low with no pulse. If the command is raised again during the same dead-time, the output rises only when the dead-time ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lo | input | 1 | Low-side switch command, active high |
| cmd_hi | input | 1 | High-side switch command, active high |
| uvlo_main | input | 1 | Main-supply undervoltage flag, active high |
| uvlo_float | input | 1 | Floating-supply undervoltage flag, active high |
| gate_lo | output | 1 | Low-side gate enable |
| gate_hi | output | 1 | High-side gate enable |

## Verification
Each dead-time counter holds one piece of state. If it is wrong, the outputs show it at the next handover: a gate turns on early, which shortens the off gap below `DEAD_CYC`, or it turns on late, which adds delay to a handover that had a long gap. In both cases the error appears within `DEAD_CYC+3` cycles of the off edge. A fault in the interlock or in the lockout gating shows up three cycles after the input pattern that should have blocked an output. The directed scenarios sample the outputs one cycle before and exactly on each expected edge, so an error of a single cycle is caught.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int SIDE_LO = 0;
  localparam int SIDE_HI = 1;
  localparam int N_SIDES = 2;
  // Bit positions of the synchronized input bundle
  localparam int IN_CMD_LO  = 0;
  localparam int IN_CMD_HI  = 1;
  localparam int IN_UV_MAIN = 2;
  localparam int IN_UV_FLT  = 3;
  localparam int N_INPUTS   = 4;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
  parameter int DEAD_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_now,
  input  logic gate_nxt,
  output logic expired
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          fall;

  always_comb begin
    fall   = gate_now & ~gate_nxt;
    cnt_en = fall | (cnt_q != LIMIT);
    cnt_d  = fall ? ONE : cnt_q + ONE;
  end

  // Reset preloads the counter as expired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LIMIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_pkg::*;
(
  input  logic [N_SIDES-1:0] cmd_s,
  input  logic               uv_main_s,
  input  logic               uv_flt_s,
  input  logic [N_SIDES-1:0] gate_q,
  input  logic [N_SIDES-1:0] expired,
  output logic [N_SIDES-1:0] gate_d
);
  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    localparam int PEER = N_SIDES - 1 - s;
    logic want, uv_block;
    always_comb begin
      uv_block  = uv_main_s | ((s == SIDE_HI) ? uv_flt_s : 1'b0);
      want      = cmd_s[s] & ~cmd_s[PEER] & ~uv_block;
      gate_d[s] = want & ~gate_q[PEER] & expired[PEER];
    end
  end
endmodule

// File: rtl/hb_gate_ctl.sv
module hb_gate_ctl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_lo,
  input  logic cmd_hi,
  input  logic uvlo_main,
  input  logic uvlo_float,
  output logic gate_lo,
  output logic gate_hi
);
  logic [N_INPUTS-1:0] raw_in, sync_in;
  logic [N_SIDES-1:0]  cmd_s;
  logic [N_SIDES-1:0]  gate_q, gate_d, expired;

  always_comb begin
    raw_in             = '0;
    raw_in[IN_CMD_LO]  = cmd_lo;
    raw_in[IN_CMD_HI]  = cmd_hi;
    raw_in[IN_UV_MAIN] = uvlo_main;
    raw_in[IN_UV_FLT]  = uvlo_float;
    cmd_s[SIDE_LO]     = sync_in[IN_CMD_LO];
    cmd_s[SIDE_HI]     = sync_in[IN_CMD_HI];
  end

  hb_sync #(.WIDTH(N_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  hb_interlock u_ilk (
    .cmd_s(cmd_s), .uv_main_s(sync_in[IN_UV_MAIN]), .uv_flt_s(sync_in[IN_UV_FLT]),
    .gate_q(gate_q), .expired(expired), .gate_d(gate_d)
  );

  for (genvar s = 0; s < N_SIDES; s++) begin : g_timer
    hb_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .gate_now(gate_q[s]), .gate_nxt(gate_d[s]),
      .expired(expired[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_d;
  end

  assign gate_lo = gate_q[SIDE_LO];
  assign gate_hi = gate_q[SIDE_HI];
endmodule

// File: rtl/hb_gate_ctl_chk.sv
module hb_gate_ctl_chk #(
  parameter int DEAD_CYC = 32,
  parameter int LAT      = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_lo,
  input logic cmd_hi,
  input logic uvlo_main,
  input logic uvlo_float,
  input logic gate_lo,
  input logic gate_hi
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC);

  logic [LAT-1:0] lo_d, hi_d, um_d, uf_d;
  logic           lo_q, hi_q;
  logic [CW-1:0]  since_lo_off, since_hi_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_d <= '0; hi_d <= '0; um_d <= '0; uf_d <= '0;
      lo_q <= 1'b0; hi_q <= 1'b0;
      since_lo_off <= LIMIT; since_hi_off <= LIMIT;
    end else begin
      lo_d <= {lo_d[LAT-2:0], cmd_lo};
      hi_d <= {hi_d[LAT-2:0], cmd_hi};
      um_d <= {um_d[LAT-2:0], uvlo_main};
      uf_d <= {uf_d[LAT-2:0], uvlo_float};
      lo_q <= gate_lo;
      hi_q <= gate_hi;
      if (lo_q && !gate_lo)          since_lo_off <= CW'(1);
      else if (since_lo_off != LIMIT) since_lo_off <= since_lo_off + CW'(1);
      if (hi_q && !gate_hi)          since_hi_off <= CW'(1);
      else if (since_hi_off != LIMIT) since_hi_off <= since_hi_off + CW'(1);
    end
  end

  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi));

  a_r1_both_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_d[LAT-1] && hi_d[LAT-1]) |-> (!gate_lo && !gate_hi));

  a_r3_lo_to_hi_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_q && !gate_lo) || (since_lo_off < LIMIT)) |-> !gate_hi);

  a_r4_hi_to_lo_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_q && !gate_hi) || (since_hi_off < LIMIT)) |-> !gate_lo);

  a_r6_rise_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (hi_d[LAT-1] && !lo_d[LAT-1]));

  a_r7_main_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    um_d[LAT-1] |-> (!gate_lo && !gate_hi));

  a_r8_float_uv_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
    uf_d[LAT-1] |-> !gate_hi);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_low: assert (!gate_lo && !gate_hi);
    end
  end
endmodule

bind hb_gate_ctl hb_gate_ctl_chk #(.DEAD_CYC(DEAD_CYC), .LAT(SYNC_STAGES + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
  .uvlo_main(uvlo_main), .uvlo_float(uvlo_float),
  .gate_lo(gate_lo), .gate_hi(gate_hi)
);

// File: tb/hb_gate_ctl_tb_top.sv
`timescale 1ns/1ps
module hb_gate_ctl_tb_top;
  localparam int DT  = 32;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n, cmd_lo, cmd_hi, uvlo_main, uvlo_float;
  logic gate_lo, gate_hi;
  int   n_chk = 0, n_bad = 0, both_on = 0;

  always #5 clk = ~clk;

  hb_gate_ctl #(.DEAD_CYC(DT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .uvlo_main(uvlo_main), .uvlo_float(uvlo_float),
    .gate_lo(gate_lo), .gate_hi(gate_hi)
  );

  always @(negedge clk) if (rst_n === 1'b1 && gate_lo && gate_hi) both_on++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {lo,hi} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    cmd_lo = 0; cmd_hi = 0; uvlo_main = 0; uvlo_float = 0;
    tick(DT + 8);
  endtask

  task automatic t_reset();  // R9
    rst_n = 0; cmd_lo = 1; cmd_hi = 0; uvlo_main = 0; uvlo_float = 0;
    tick(4);
    chk("R9 outputs low in reset", {gate_lo, gate_hi}, 2'b00);
    rst_n = 1;
    tick(LAT - 1);
    chk("R9 before latency", {gate_lo, gate_hi}, 2'b00);
    tick(1);
    chk("R9 first command undelayed", {gate_lo, gate_hi}, 2'b10);
    idle();
  endtask

  task automatic t_truth();  // R1
    cmd_lo = 0; cmd_hi = 0; tick(DT + 6);
    chk("R1 none", {gate_lo, gate_hi}, 2'b00);
    cmd_hi = 1; tick(DT + 6);
    chk("R1 hi only", {gate_lo, gate_hi}, 2'b01);
    cmd_hi = 0; cmd_lo = 1; tick(DT + 6);
    chk("R1 lo only", {gate_lo, gate_hi}, 2'b10);
    cmd_hi = 1; tick(DT + 6);
    chk("R1 both", {gate_lo, gate_hi}, 2'b00);
    idle();
  endtask

  task automatic t_lo_to_hi();  // R3
    cmd_lo = 1; tick(DT + 6);
    cmd_lo = 0; cmd_hi = 1;
    tick(LAT);
    chk("R3 lo off", {gate_lo, gate_hi}, 2'b00);
    tick(DT - 1);
    chk("R3 hi held one cycle before", {gate_lo, gate_hi}, 2'b00);
    tick(1);
    chk("R3 hi on after dead-time", {gate_lo, gate_hi}, 2'b01);
    idle();
  endtask

  task automatic t_hi_to_lo();  // R4
    cmd_hi = 1; tick(DT + 6);
    cmd_hi = 0; cmd_lo = 1;
    tick(LAT + DT - 1);
    chk("R4 lo held one cycle before", {gate_lo, gate_hi}, 2'b00);
    tick(1);
    chk("R4 lo on after dead-time", {gate_lo, gate_hi}, 2'b10);
    idle();
  endtask

  task automatic t_overlap();  // R5
    cmd_lo = 1; tick(DT + 6);
    cmd_hi = 1;             // overlap starts
    tick(5);
    cmd_lo = 0;             // overlap ends early
    tick(LAT + DT - 1 - 5);
    chk("R5 hi held before full dead-time", {gate_lo, gate_hi}, 2'b00);
    tick(1);
    chk("R5 hi on full dead-time after both off", {gate_lo, gate_hi}, 2'b01);
    idle();
  endtask

  task automatic t_gap(input int gap, input int extra);  // R6
    cmd_lo = 1; tick(DT + 6);
    cmd_lo = 0; tick(gap);
    cmd_hi = 1;
    tick(LAT + extra - 1);
    chk($sformatf("R6 gap %0d one cycle before", gap), {gate_lo, gate_hi}, 2'b00);
    tick(1);
    chk($sformatf("R6 gap %0d on", gap), {gate_lo, gate_hi}, 2'b01);
    idle();
  endtask

  task automatic t_uv_main();  // R7
    cmd_lo = 1; tick(DT + 6);
    uvlo_main = 1; tick(LAT);
    chk("R7 lo forced off", {gate_lo, gate_hi}, 2'b00);
    cmd_lo = 0; cmd_hi = 1; tick(DT + 6);
    chk("R7 hi blocked", {gate_lo, gate_hi}, 2'b00);
    uvlo_main = 0; tick(LAT);
    chk("R7 release follows latency", {gate_lo, gate_hi}, 2'b01);
    idle();
  endtask

  task automatic t_uv_float();  // R8
    cmd_hi = 1; tick(DT + 6);
    uvlo_float = 1; tick(LAT);
    chk("R8 hi forced off", {gate_lo, gate_hi}, 2'b00);
    cmd_hi = 0; cmd_lo = 1; tick(DT + 6);
    chk("R8 lo still works", {gate_lo, gate_hi}, 2'b10);
    idle();
  endtask

  task automatic t_cancel();  // R10
    cmd_lo = 1; tick(DT + 6);
    cmd_lo = 0; cmd_hi = 1; tick(LAT + 4);
    cmd_hi = 0;             // drop inside dead-time
    for (int i = 0; i < DT + 6; i++) begin
      tick(1);
      if (gate_hi) begin chk("R10 cancelled no pulse", {gate_lo, gate_hi}, 2'b00); break; end
    end
    chk("R10 cancelled stays off", {gate_lo, gate_hi}, 2'b00);
    idle();
    cmd_lo = 1; tick(DT + 6);
    cmd_lo = 0; cmd_hi = 1; tick(5);
    cmd_hi = 0; tick(5);
    cmd_hi = 1;             // re-asserted during dead-time
    tick(LAT + DT - 1 - 10);
    chk("R10 reassert waits", {gate_lo, gate_hi}, 2'b00);
    tick(1);
    chk("R10 reassert on at expiry", {gate_lo, gate_hi}, 2'b01);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_truth();
    t_lo_to_hi();
    t_hi_to_lo();
    t_overlap();
    t_gap(DT, 0);
    t_gap(DT + 10, 0);
    t_gap(DT - 1, 1);
    t_uv_main();
    t_uv_float();
    t_cancel();
    n_chk++;
    if (both_on != 0) begin
      n_bad++;
      $display("FAIL R2 both outputs high: actual=%0d cycles expected=0", both_on);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule